// File: doc/BRIEF.md
# Transmit Descriptor Ring Fetch Engine

The engine lets a host queue outgoing frames through a ring of descriptors kept in memory. Each descriptor is 16 bytes. The host fills in descriptors and sets their ownership bit. It then rings a doorbell by writing the poll register. The engine walks the ring from its current position. For each descriptor it owns, it reads the buffer address, streams the buffer out of the frame port as 32-bit beats, and writes the control word back with ownership returned to the host. It then moves to the next descriptor. It stops and raises a descriptor-unavailable pulse at the first descriptor it does not own. The ring closes on a per-descriptor end-of-ring flag rather than on a fixed count.

All memory traffic uses one request/response word port with a single access in flight. The frame port has no backpressure. One pulse reports each finished descriptor: transmit-OK for a frame that was sent, or transmit-error for a descriptor that was refused.

Top module: `txring_engine`

## Requirements
- R1: After reset, mem_req_o, frm_valid_o and all three status pulses are low, and no memory request is issued until a doorbell arrives.
- R2: Only a write with reg_sel_i = 2 and reg_wdata_i bit 6 set is a doorbell. A poll write with bit 6 clear starts no memory traffic.
- R3: Descriptor layout and access order. The control word is read at offset 0; buffer address low is read at 8 and buffer address high at 12. In the control word, bit 31 means the device owns it, bit 30 is end of ring, bit 29 is first segment and bit 28 is last segment. Bits 15:0 hold the frame length in bytes. Every access is word-aligned, and a new request is issued only after the previous one has been answered.
- R4: An accepted descriptor produces ceil(len/4) beats taken in ascending order from the buffer. frm_sof_o is set on the first beat and frm_eof_o on the last. frm_keep_o is 4'hF on every beat except the last, where it marks the bytes that remain: len mod 4 of 1, 2, 3 or 0 gives 4'h1, 4'h3, 4'h7 or 4'hF. Byte 0 of the frame is in bits 7:0.
- R5: After a frame, the control word is written back with only bit 31 cleared, and then tx_ok_o pulses for one cycle.
- R6: The next descriptor is at the current address plus 16. After a descriptor with end of ring set, the next one is at the ring base.
- R7: On reading a control word with bit 31 clear, desc_unavail_o pulses and the engine makes no further requests. The next doorbell resumes at that same descriptor.
- R8: An owned descriptor that lacks either segment bit, or has length 0, produces no beats. It is still written back with bit 31 cleared, and then tx_err_o pulses. At most one status pulse is high in any cycle.
- R9: The ring base is {sel 1 word, sel 0 word} with bits 7:0 forced to zero. Writing either half moves the fetch position to the new base.
- R10: A doorbell that arrives while the engine is running is kept, even in the same cycle as the ownership check that stops the engine. The engine rescans from the stopping descriptor once more.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_sel_i | input | 2 | 0 base low, 1 base high, 2 poll |
| reg_wdata_i | input | 32 | Register write data |
| mem_req_o | output | 1 | Memory request, one cycle per access |
| mem_we_o | output | 1 | Request is a write |
| mem_addr_o | output | 64 | Byte address of the word |
| mem_wdata_o | output | 32 | Write data |
| mem_rvalid_i | input | 1 | Response (read data or write acknowledge) |
| mem_rdata_i | input | 32 | Read data |
| frm_valid_o | output | 1 | Frame beat valid |
| frm_data_o | output | 32 | Frame beat data |
| frm_keep_o | output | 4 | Valid bytes of the beat |
| frm_sof_o | output | 1 | First beat of a frame |
| frm_eof_o | output | 1 | Last beat of a frame |
| tx_ok_o | output | 1 | Frame sent and returned to host |
| tx_err_o | output | 1 | Descriptor refused and returned to host |
| desc_unavail_o | output | 1 | Stopped at a host-owned descriptor |

## Verification
The doorbell write and the ownership check that stops the engine can land on the same clock edge. That collision is where a pending poll is most likely to be dropped. The bench's memory model produces it on purpose. When it returns the unowned control word at a chosen address, it drives a poll write in that same cycle and then sets the ownership bit in memory. The collision is judged correct only if the engine reads that descriptor again, streams its frame, and reports a second stop at the following descriptor. A separate sweep also rings the doorbell mid-run and expects exactly one extra rescan.

// File: rtl/txr_pkg.sv
package txr_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_CTL, ST_ADL, ST_ADH, ST_DAT, ST_WB
  } txr_state_e;

  localparam int unsigned OWN_B = 31;
  localparam int unsigned EOR_B = 30;
  localparam int unsigned FS_B  = 29;
  localparam int unsigned LS_B  = 28;

  localparam logic [1:0] SEL_BASE_LO = 2'd0;
  localparam logic [1:0] SEL_BASE_HI = 2'd1;
  localparam logic [1:0] SEL_POLL    = 2'd2;
  localparam int unsigned POLL_B     = 6;

  localparam int unsigned DESC_STRIDE = 16;
  localparam int unsigned OFF_ADL     = 8;
  localparam int unsigned OFF_ADH     = 12;
endpackage

// File: rtl/txr_regs.sv
module txr_regs
  import txr_pkg::*;
#(
  parameter int unsigned AW        = 64,
  parameter int unsigned ALIGN_LSB = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [1:0]    sel_i,
  input  logic [31:0]   wdata_i,
  input  logic          consume_i,
  output logic [AW-1:0] base_o,
  output logic          load_o,
  output logic          pend_o
);
  localparam int unsigned HI_W = AW - 32;
  localparam logic [AW-1:0] ALIGN_MASK = (AW'(1) << ALIGN_LSB) - AW'(1);

  logic [31:0]     lo_q;
  logic [HI_W-1:0] hi_q;
  logic            load_q, pend_q;
  logic            ring_set;

  assign ring_set = we_i && sel_i == SEL_POLL && wdata_i[POLL_B];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lo_q   <= '0;
      hi_q   <= '0;
      load_q <= 1'b0;
      pend_q <= 1'b0;
    end else begin
      if (we_i && sel_i == SEL_BASE_LO) lo_q <= wdata_i;
      if (we_i && sel_i == SEL_BASE_HI) hi_q <= wdata_i[HI_W-1:0];
      load_q <= we_i && (sel_i == SEL_BASE_LO || sel_i == SEL_BASE_HI);
      // a new ring wins over a same-cycle consume
      pend_q <= ring_set | (pend_q & ~consume_i);
    end
  end

  assign base_o = {hi_q, lo_q} & ~ALIGN_MASK;
  assign load_o = load_q;
  assign pend_o = pend_q;
endmodule

// File: rtl/txr_ring_ptr.sv
module txr_ring_ptr
  import txr_pkg::*;
#(
  parameter int unsigned AW = 64
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [AW-1:0] base_i,
  input  logic          adv_i,
  input  logic          eor_i,
  output logic [AW-1:0] cur_o
);
  logic [AW-1:0] cur_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cur_q <= '0;
    else if (load_i) cur_q <= base_i;
    else if (adv_i)  cur_q <= eor_i ? base_i : cur_q + AW'(DESC_STRIDE);
  end

  assign cur_o = cur_q;
endmodule

// File: rtl/txr_seq.sv
module txr_seq
  import txr_pkg::*;
#(
  parameter int unsigned AW    = 64,
  parameter int unsigned LEN_W = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          pend_i,
  output logic          consume_o,
  input  logic [AW-1:0] cur_i,
  output logic          adv_o,
  output logic          eor_o,
  output logic          mem_req_o,
  output logic          mem_we_o,
  output logic [AW-1:0] mem_addr_o,
  output logic [31:0]   mem_wdata_o,
  input  logic          mem_rvalid_i,
  input  logic [31:0]   mem_rdata_i,
  output logic          frm_valid_o,
  output logic [31:0]   frm_data_o,
  output logic [3:0]    frm_keep_o,
  output logic          frm_sof_o,
  output logic          frm_eof_o,
  output logic          tx_ok_o,
  output logic          tx_err_o,
  output logic          desc_unavail_o
);
  localparam int unsigned WC_W = LEN_W - 2;

  txr_state_e       st_q;
  logic             wait_q;
  logic [31:0]      ctl_q;
  logic [AW-1:0]    buf_q;
  logic [WC_W-1:0]  widx_q;
  logic [LEN_W-1:0] len_m1;
  logic             resp, rd_good, ctl_good, last_beat;
  logic [3:0]       tail_keep;

  assign resp      = mem_rvalid_i && wait_q;
  assign rd_good   = mem_rdata_i[FS_B] && mem_rdata_i[LS_B] && (mem_rdata_i[LEN_W-1:0] != '0);
  assign ctl_good  = ctl_q[FS_B] && ctl_q[LS_B] && (ctl_q[LEN_W-1:0] != '0);
  assign len_m1    = ctl_q[LEN_W-1:0] - LEN_W'(1);
  assign last_beat = widx_q == len_m1[LEN_W-1:2];

  always_comb begin
    unique case (len_m1[1:0])
      2'd0:    tail_keep = 4'h1;
      2'd1:    tail_keep = 4'h3;
      2'd2:    tail_keep = 4'h7;
      default: tail_keep = 4'hF;
    endcase
  end

  assign mem_req_o   = (st_q != ST_IDLE) && !wait_q;
  assign mem_we_o    = st_q == ST_WB;
  assign mem_wdata_o = {1'b0, ctl_q[30:0]};
  assign consume_o   = (st_q == ST_IDLE) && pend_i;
  assign adv_o       = resp && st_q == ST_WB;
  assign eor_o       = ctl_q[EOR_B];

  always_comb begin
    unique case (st_q)
      ST_ADL:  mem_addr_o = cur_i + AW'(OFF_ADL);
      ST_ADH:  mem_addr_o = cur_i + AW'(OFF_ADH);
      ST_DAT:  mem_addr_o = buf_q + {{(AW-WC_W-2){1'b0}}, widx_q, 2'b00};
      default: mem_addr_o = cur_i;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q           <= ST_IDLE;
      wait_q         <= 1'b0;
      ctl_q          <= '0;
      buf_q          <= '0;
      widx_q         <= '0;
      frm_valid_o    <= 1'b0;
      frm_data_o     <= '0;
      frm_keep_o     <= '0;
      frm_sof_o      <= 1'b0;
      frm_eof_o      <= 1'b0;
      tx_ok_o        <= 1'b0;
      tx_err_o       <= 1'b0;
      desc_unavail_o <= 1'b0;
    end else begin
      frm_valid_o    <= 1'b0;
      frm_sof_o      <= 1'b0;
      frm_eof_o      <= 1'b0;
      frm_keep_o     <= '0;
      tx_ok_o        <= 1'b0;
      tx_err_o       <= 1'b0;
      desc_unavail_o <= 1'b0;

      if (mem_req_o) wait_q <= 1'b1;
      else if (resp) wait_q <= 1'b0;

      unique case (st_q)
        ST_IDLE: if (pend_i) st_q <= ST_CTL;
        ST_CTL: if (resp) begin
          ctl_q <= mem_rdata_i;
          if (!mem_rdata_i[OWN_B]) begin
            desc_unavail_o <= 1'b1;
            st_q           <= ST_IDLE;
          end else begin
            st_q <= rd_good ? ST_ADL : ST_WB;
          end
        end
        ST_ADL: if (resp) begin
          buf_q[31:0] <= {mem_rdata_i[31:2], 2'b00};
          st_q        <= ST_ADH;
        end
        ST_ADH: if (resp) begin
          buf_q[AW-1:32] <= mem_rdata_i[AW-33:0];
          widx_q         <= '0;
          st_q           <= ST_DAT;
        end
        ST_DAT: if (resp) begin
          frm_valid_o <= 1'b1;
          frm_data_o  <= mem_rdata_i;
          frm_sof_o   <= widx_q == '0;
          frm_eof_o   <= last_beat;
          frm_keep_o  <= last_beat ? tail_keep : 4'hF;
          if (last_beat) st_q <= ST_WB;
          else           widx_q <= widx_q + WC_W'(1);
        end
        ST_WB: if (resp) begin
          if (ctl_good) tx_ok_o  <= 1'b1;
          else          tx_err_o <= 1'b1;
          st_q <= ST_CTL;
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/txring_engine.sv
module txring_engine
  import txr_pkg::*;
#(
  parameter int unsigned AW        = 64,
  parameter int unsigned LEN_W     = 16,
  parameter int unsigned ALIGN_LSB = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          reg_we_i,
  input  logic [1:0]    reg_sel_i,
  input  logic [31:0]   reg_wdata_i,
  output logic          mem_req_o,
  output logic          mem_we_o,
  output logic [AW-1:0] mem_addr_o,
  output logic [31:0]   mem_wdata_o,
  input  logic          mem_rvalid_i,
  input  logic [31:0]   mem_rdata_i,
  output logic          frm_valid_o,
  output logic [31:0]   frm_data_o,
  output logic [3:0]    frm_keep_o,
  output logic          frm_sof_o,
  output logic          frm_eof_o,
  output logic          tx_ok_o,
  output logic          tx_err_o,
  output logic          desc_unavail_o
);
  logic [AW-1:0] base, cur;
  logic          load, pend, consume, adv, eor;

  txr_regs #(.AW(AW), .ALIGN_LSB(ALIGN_LSB)) u_regs (
    .clk_i, .rst_ni,
    .we_i(reg_we_i), .sel_i(reg_sel_i), .wdata_i(reg_wdata_i),
    .consume_i(consume), .base_o(base), .load_o(load), .pend_o(pend)
  );

  txr_ring_ptr #(.AW(AW)) u_ptr (
    .clk_i, .rst_ni,
    .load_i(load), .base_i(base), .adv_i(adv), .eor_i(eor), .cur_o(cur)
  );

  txr_seq #(.AW(AW), .LEN_W(LEN_W)) u_seq (
    .clk_i, .rst_ni,
    .pend_i(pend), .consume_o(consume), .cur_i(cur), .adv_o(adv), .eor_o(eor),
    .mem_req_o, .mem_we_o, .mem_addr_o, .mem_wdata_o, .mem_rvalid_i, .mem_rdata_i,
    .frm_valid_o, .frm_data_o, .frm_keep_o, .frm_sof_o, .frm_eof_o,
    .tx_ok_o, .tx_err_o, .desc_unavail_o
  );
endmodule

// File: rtl/txring_engine_chk.sv
module txring_engine_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       req_i,
  input logic       we_i,
  input logic [1:0] addr_lo_i,
  input logic       wb_own_i,
  input logic       rvalid_i,
  input logic       fv_i,
  input logic [3:0] keep_i,
  input logic       sof_i,
  input logic       eof_i,
  input logic       ok_i,
  input logic       err_i,
  input logic       unav_i
);
  logic in_frame, outst;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      in_frame <= 1'b0;
      outst    <= 1'b0;
    end else begin
      if (fv_i) in_frame <= !eof_i;
      if (req_i) outst <= 1'b1;
      else if (rvalid_i) outst <= 1'b0;
    end
  end

  a_r5_wb_clears_own: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i && we_i |-> !wb_own_i);
  a_r3_word_aligned: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i |-> addr_lo_i == 2'b00);
  a_r3_single_outstanding: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i |-> !outst);
  a_r4_sof_outside_frame: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fv_i && sof_i |-> !in_frame);
  a_r4_beat_inside_frame: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fv_i && !sof_i |-> in_frame);
  a_r4_keep_full_mid: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fv_i && !eof_i |-> keep_i == 4'hF);
  a_r8_status_exclusive: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({ok_i, err_i, unav_i}));
  a_r5_ok_after_frame: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ok_i |-> !in_frame && !fv_i);
endmodule

bind txring_engine txring_engine_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni),
  .req_i(mem_req_o), .we_i(mem_we_o), .addr_lo_i(mem_addr_o[1:0]),
  .wb_own_i(mem_wdata_o[31]), .rvalid_i(mem_rvalid_i),
  .fv_i(frm_valid_o), .keep_i(frm_keep_o), .sof_i(frm_sof_o), .eof_i(frm_eof_o),
  .ok_i(tx_ok_o), .err_i(tx_err_o), .unav_i(desc_unavail_o)
);

// File: tb/txring_engine_bench.sv
module txring_engine_bench;
  localparam logic [31:0] OWN = 32'h8000_0000, EOR = 32'h4000_0000;
  localparam logic [31:0] FS = 32'h2000_0000, LS = 32'h1000_0000;

  logic clk = 1'b0, rst_n = 1'b0;
  always #2 clk = ~clk;

  logic we_t = 1'b0, db_auto = 1'b0;
  logic [1:0] sel_t = '0;
  logic [31:0] wd_t = '0;
  logic reg_we; logic [1:0] reg_sel; logic [31:0] reg_wd;
  assign reg_we  = we_t | db_auto;
  assign reg_sel = db_auto ? 2'd2 : sel_t;
  assign reg_wd  = db_auto ? 32'h40 : wd_t;

  logic mem_req, mem_we, mem_rvalid = 1'b0;
  logic [63:0] mem_addr;
  logic [31:0] mem_wdata, mem_rdata = '0;
  logic fv, sof, eof, ok, err, unav;
  logic [31:0] fdata;
  logic [3:0] keep;

  txring_engine u_txring_engine (
    .clk_i(clk), .rst_ni(rst_n),
    .reg_we_i(reg_we), .reg_sel_i(reg_sel), .reg_wdata_i(reg_wd),
    .mem_req_o(mem_req), .mem_we_o(mem_we), .mem_addr_o(mem_addr), .mem_wdata_o(mem_wdata),
    .mem_rvalid_i(mem_rvalid), .mem_rdata_i(mem_rdata),
    .frm_valid_o(fv), .frm_data_o(fdata), .frm_keep_o(keep), .frm_sof_o(sof), .frm_eof_o(eof),
    .tx_ok_o(ok), .tx_err_o(err), .desc_unavail_o(unav)
  );

  logic [31:0] mem [0:1023];
  int lat = 1, cnt = 0, nreq = 0, hi_err = 0, arm_hit = 0;
  logic [31:0] exp_hi = '0;
  logic [9:0] r_idx = '0, arm_idx = '0;
  logic r_we = 1'b0, arm = 1'b0, log_en = 1'b0;
  logic [63:0] log_addr = '0;
  int checks = 0, fails = 0;

  int exp_buf [0:31];
  int exp_len [0:31];
  int n_exp = 0;
  int mchecks = 0, mfails = 0, n_ok = 0, n_err = 0, n_un = 0, rx_fi = 0, rx_wi = 0;

  function automatic logic [31:0] pat(input int a);
    return {16'(a) ^ 16'h3C3C, 16'(a)};
  endfunction

  // frame and status monitor
  always @(negedge clk) begin
    int nw;
    int ea;
    logic [3:0] ek;
    if (rst_n) begin
      if (ok) n_ok++;
      if (err) n_err++;
      if (unav) n_un++;
      if (fv) begin
        mchecks++;
        if (rx_fi >= n_exp) begin
          mfails++;
          $display("FAIL R4 unexpected beat act=%h exp=none", fdata);
        end else begin
          nw = (exp_len[rx_fi] + 3) / 4;
          ea = exp_buf[rx_fi] + 4 * rx_wi;
          case (exp_len[rx_fi] % 4)
            1: ek = 4'h1; 2: ek = 4'h3; 3: ek = 4'h7; default: ek = 4'hF;
          endcase
          if (rx_wi != nw - 1) ek = 4'hF;
          if (fdata != pat(ea) || sof != (rx_wi == 0) || eof != (rx_wi == nw - 1) || keep != ek) begin
            mfails++;
            $display("FAIL R4 frame %0d beat %0d act=%h/%b/%b/%h exp=%h/%b/%b/%h", rx_fi, rx_wi,
                     fdata, sof, eof, keep, pat(ea), rx_wi == 0, rx_wi == nw - 1, ek);
          end
          if (rx_wi >= nw - 1) begin rx_fi++; rx_wi = 0; end
          else rx_wi++;
        end
      end
    end
  end

  task automatic model_step();
    db_auto = 1'b0;
    mem_rvalid = 1'b0;
    if (cnt > 0) begin
      cnt--;
      if (cnt == 0) begin
        mem_rvalid = 1'b1;
        if (!r_we) mem_rdata = mem[r_idx];
        if (arm && !r_we && r_idx == arm_idx) begin
          db_auto = 1'b1;
          arm = 1'b0;
          arm_hit++;
          mem[r_idx][31] = 1'b1;
        end
      end
    end
    if (rst_n && mem_req) begin
      r_idx = mem_addr[11:2];
      r_we  = mem_we;
      if (mem_we) mem[r_idx] = mem_wdata;
      cnt = lat;
      nreq++;
      if (log_en) begin log_addr = mem_addr; log_en = 1'b0; end
      if (mem_addr[11] == 1'b0) begin
        if (mem_addr[63:32] != exp_hi) hi_err++;
      end else if (mem_addr[63:32] != 32'h0) hi_err++;
    end
  endtask

  task automatic check(input logic cond, input string tag, input logic [63:0] act, input logic [63:0] expv);
    checks++;
    if (!cond) begin
      fails++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, expv);
    end
  endtask

  task automatic reg_wr(input logic [1:0] s, input logic [31:0] d);
    @(negedge clk); we_t = 1'b1; sel_t = s; wd_t = d;
    @(negedge clk); we_t = 1'b0;
  endtask

  task automatic put_desc(input int a, input logic [31:0] ctl, input int b, input int len, input logic expect_frame);
    mem[a >> 2] = ctl;
    mem[(a >> 2) + 1] = 32'h0;
    mem[(a >> 2) + 2] = 32'(b);
    mem[(a >> 2) + 3] = 32'h0;
    for (int k = 0; k < 16; k++) mem[(b >> 2) + k] = pat(b + 4 * k);
    if (expect_frame) begin
      exp_buf[n_exp] = b; exp_len[n_exp] = len; n_exp++;
    end
  endtask

  task automatic wait_un(input int k);
    int t = 0;
    while (n_un < k && t < 4000) begin @(negedge clk); t++; end
    repeat (20) @(negedge clk);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    $display("FAIL R1 watchdog act=running exp=finished");
    $display("== %0d vectors applied, %0d miscompares ==", checks + mchecks + 1, fails + mfails + 1);
    $finish;
  end

  initial begin : main
    int ok0, err0, un0, fr0, nr0, hit0;
    logic [31:0] c [0:3];
    for (int i = 0; i < 1024; i++) mem[i] = 32'h0;
    fork
      forever begin @(negedge clk); model_step(); end
    join_none

    // R1 reset state
    repeat (3) @(negedge clk);
    check(!mem_req && !fv && !ok && !err && !unav, "R1 outputs in reset", {mem_req, fv, ok, err, unav}, 0);
    rst_n = 1'b1;
    repeat (10) @(negedge clk);
    check(nreq == 0, "R1 no request after reset", nreq, 0);

    // R2 poll write without bit 6
    put_desc(32'h100, OWN | FS | LS | EOR | 32'd4, 32'h800, 4, 1'b0);
    reg_wr(2'd0, 32'h100);
    reg_wr(2'd2, 32'hFFFF_FFBF);
    repeat (30) @(negedge clk);
    check(nreq == 0, "R2 poll without bit6 ignored", nreq, 0);
    check(rx_fi == 0, "R2 no frame", rx_fi, 0);

    // R4 R5 R6 R10 sweep over latency and lengths
    for (int l = 1; l <= 3; l++) begin
      lat = l;
      for (int i = 0; i < 4; i++) begin
        c[i] = OWN | FS | LS | 32'h0010_0000 | (i == 3 ? EOR : 32'h0) | 32'(1 + 5 * i + l);
        put_desc(32'h100 + 16 * i, c[i], 32'h800 + 64 * i, 1 + 5 * i + l, 1'b1);
      end
      reg_wr(2'd0, 32'h100);
      ok0 = n_ok; un0 = n_un;
      reg_wr(2'd2, 32'h40);
      repeat (3) @(negedge clk);
      reg_wr(2'd2, 32'h40);
      wait_un(un0 + 2);
      check(n_ok - ok0 == 4, "R5 tx_ok count", n_ok - ok0, 4);
      check(rx_fi == n_exp, "R4 frames delivered", rx_fi, n_exp);
      check(n_un - un0 == 2, "R10 mid-run doorbell rescans once", n_un - un0, 2);
      for (int i = 0; i < 4; i++)
        check(mem[(32'h100 >> 2) + 4 * i] == (c[i] & 32'h7FFF_FFFF), "R5 writeback clears bit31 only",
              mem[(32'h100 >> 2) + 4 * i], c[i] & 32'h7FFF_FFFF);
      // wrap: next fetch must be at the base
      put_desc(32'h100, OWN | FS | LS | 32'd5, 32'h800, 5, 1'b1);
      ok0 = n_ok; un0 = n_un;
      reg_wr(2'd2, 32'h40);
      wait_un(un0 + 1);
      check(n_ok - ok0 == 1 && rx_fi == n_exp, "R6 wrap to base after end of ring", n_ok - ok0, 1);
      check(mem[32'h100 >> 2] == (FS | LS | 32'd5), "R6 wrapped descriptor returned", mem[32'h100 >> 2], FS | LS | 32'd5);
    end

    // R8 refused descriptors
    lat = 2;
    put_desc(32'h300, OWN | FS | 32'd8, 32'h840, 8, 1'b0);
    put_desc(32'h310, OWN | FS | LS | 32'd0, 32'h880, 0, 1'b0);
    put_desc(32'h320, OWN | FS | LS | EOR | 32'd3, 32'h8C0, 3, 1'b1);
    reg_wr(2'd0, 32'h300);
    ok0 = n_ok; err0 = n_err; un0 = n_un;
    reg_wr(2'd2, 32'h40);
    wait_un(un0 + 1);
    check(n_err - err0 == 2, "R8 tx_err count", n_err - err0, 2);
    check(n_ok - ok0 == 1, "R8 good neighbour still sent", n_ok - ok0, 1);
    check(rx_fi == n_exp, "R8 no beats for refused", rx_fi, n_exp);
    check(mem[32'h300 >> 2] == (FS | 32'd8), "R8 refused returned", mem[32'h300 >> 2], FS | 32'd8);
    check(mem[32'h310 >> 2] == (FS | LS), "R8 zero length returned", mem[32'h310 >> 2], FS | LS);

    // R9 base with upper half and unaligned low bits
    exp_hi = 32'h1;
    put_desc(32'h100, OWN | FS | LS | EOR | 32'd6, 32'h900, 6, 1'b1);
    reg_wr(2'd1, 32'h1);
    reg_wr(2'd0, 32'h1A5);
    ok0 = n_ok; un0 = n_un; log_en = 1'b1;
    reg_wr(2'd2, 32'h40);
    wait_un(un0 + 1);
    check(log_addr == 64'h1_0000_0100, "R9 first fetch at aligned base", log_addr, 64'h1_0000_0100);
    check(hi_err == 0, "R9 upper address half", hi_err, 0);
    check(n_ok - ok0 == 1 && rx_fi == n_exp, "R9 frame from new base", n_ok - ok0, 1);
    exp_hi = 32'h0;
    reg_wr(2'd1, 32'h0);

    // R10 doorbell in the same cycle as the ownership stop, then R7
    put_desc(32'h200, OWN | FS | LS | 32'd4, 32'hA00, 4, 1'b1);
    put_desc(32'h210, FS | LS | 32'd8, 32'hA40, 8, 1'b1);
    put_desc(32'h220, FS | LS | EOR | 32'd2, 32'hA80, 2, 1'b0);
    reg_wr(2'd0, 32'h200);
    arm_idx = 10'(32'h210 >> 2); arm = 1'b1;
    ok0 = n_ok; un0 = n_un; hit0 = arm_hit;
    reg_wr(2'd2, 32'h40);
    wait_un(un0 + 2);
    check(arm_hit - hit0 == 1, "R10 collision provoked", arm_hit - hit0, 1);
    check(n_un - un0 == 2, "R10 stop count", n_un - un0, 2);
    check(n_ok - ok0 == 2 && rx_fi == n_exp, "R10 coincident doorbell kept", n_ok - ok0, 2);
    nr0 = nreq;
    repeat (40) @(negedge clk);
    check(nreq == nr0, "R7 silent after stop", nreq - nr0, 0);
    fr0 = rx_fi;
    put_desc(32'h220, OWN | FS | LS | EOR | 32'd2, 32'hA80, 2, 1'b1);
    ok0 = n_ok; un0 = n_un;
    reg_wr(2'd2, 32'h40);
    wait_un(un0 + 1);
    check(rx_fi - fr0 == 1 && n_ok - ok0 == 1, "R7 resumes at stopping descriptor", rx_fi - fr0, 1);
    check(n_un - un0 == 1, "R7 stops again at host-owned", n_un - un0, 1);

    $display("== %0d vectors applied, %0d miscompares ==", checks + mchecks, fails + mfails);
    $finish;
  end
endmodule